// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a time-division switching core for serial PCM links. It has eight serial input links and eight serial output links. Each link carries 32 eight-bit time slots per frame, which gives 256 channels on each side. Every input channel is turned into a parallel byte and stored in a speech memory at an address made from its link and slot numbers. Every output channel is filled from its own control-memory entry. An entry either points at one speech-memory location, which switches that input channel through, or it holds a constant byte that goes out as it is.

Two timebases come from one frame-sync pulse, and each is preset to its own count. The input side runs one slot behind real time, so the write stage always sees a complete byte. The output side runs one slot ahead, so every byte is fetched before it is put on the line. Within each slot, the cycles that the output fetch does not use are given to a host port with a valid/ready handshake. Through this port the control memory is written and read.

Top module: `tsi_switch`

## Requirements
- R1: After reset, every control-memory entry reads 9'h1FF (constant source, byte 0xFF), every serial output is 1, and `host_rvalid` is 0.
- R2: A frame has 512 clock cycles. The cycle in which `fsync` is high is cycle 0. Bit b (7 = MSB, sent first) of slot s takes cycles 16s+14-2b and 16s+15-2b on every link. Inputs are sampled in the second of these two cycles.
- R3: An entry with bit 8 = 0 sends the byte received on input link bits[7:5], slot bits[4:0] of the entry. Several outputs may name the same input.
- R4: An entry with bit 8 = 1 sends its bits[7:0] unchanged, whatever the inputs carry.
- R5: A request is accepted in a cycle where both `host_valid` and `host_ready` are high. `host_addr` = {output link[7:5], output slot[4:0]}. A write stores `host_wdata`. A read raises `host_rvalid` for exactly the next cycle, with the 9-bit entry on `host_rdata`. Without a read acceptance, `host_rvalid` stays low.
- R6: `host_ready` is high only in cycles 8 to 15 of each slot and low in cycles 0 to 7.
- R7: If a host write lands on the entry of output slot t during real slot t-1, it does not change the byte sent in slot t of that frame. It does change the byte sent in the next frame.
- R8: A serial output changes only at a bit boundary. It never changes between the two cycles of one bit.
- R9: The output timebase leads real time by one slot and the input timebase lags it by one slot. So the output count always exceeds the input count by two slots (32 cycles) modulo the frame.
- R10: A channel that is switched from input slot s to output slot s, on any pair of links, carries the byte of the previous frame. The switching delay is a fixed one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | One-cycle pulse marking cycle 0 of the frame |
| ser_in | input | 8 | Serial input links, MSB first |
| ser_out | output | 8 | Serial output links, MSB first |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request can be accepted this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Control entry address {link, slot} |
| host_wdata | input | 9 | Entry to write: {source, byte or speech address} |
| host_rvalid | output | 1 | Read data valid, one cycle after acceptance |
| host_rdata | output | 9 | Entry read back |

The host request side follows valid/ready rules. The host holds `host_valid`, `host_write`, `host_addr` and `host_wdata` steady until a cycle with `host_ready` high. `host_ready` does not depend on `host_valid`. A request waits at most eight cycles. The read response is a one-cycle strobe with no back-pressure, so the host must take it when it appears.

## Verification
The case hardest to reach from the ports is a host write that lands just after its own channel was fetched but before that channel's byte reaches the line. Only then does the fetch-ahead timing show whether an in-progress slot can be corrupted. The bench keeps its own frame cycle count, locked to the `fsync` it drives. It places a write to output slot 12 on cycle 8 of real slot 11, the first cycle the host is allowed. It then compares the byte captured in that frame with the byte captured in the next one. The one-frame delay of looped channels is shown by changing the input data every frame and matching each output frame against the input of the frame before.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int DEF_LINKS  = 8;
  localparam int DEF_SLOTS  = 32;
  localparam int DEF_BYTE_W = 8;

  // Output source selected by the top bit of a control entry.
  typedef enum logic {
    SRC_SPEECH = 1'b0,
    SRC_CONST  = 1'b1
  } src_sel_e;
endpackage

// File: rtl/tsi_timebase.sv
// Free-running frame counter, preset to its own value on the frame pulse.
module tsi_timebase #(
  parameter int               CNT_W    = 9,
  parameter logic [CNT_W-1:0] RST_VAL  = '0,
  parameter logic [CNT_W-1:0] SYNC_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= RST_VAL;
    else if (sync) cnt <= SYNC_VAL;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tsi_rx.sv
// Serial-to-parallel stage: one shifter per link, byte held for a full slot.
module tsi_rx #(
  parameter int LINKS  = 8,
  parameter int BYTE_W = 8,
  parameter int PH_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PH_W-1:0]               phase,
  input  logic [LINKS-1:0]              ser_in,
  output logic [LINKS-1:0][BYTE_W-1:0]  held
);
  logic [LINKS-1:0][BYTE_W-1:0] shreg;
  logic sample, last;

  assign sample = phase[0];
  assign last   = &phase;

  for (genvar g = 0; g < LINKS; g++) begin : g_link
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shreg[g] <= '0;
        held[g]  <= '0;
      end else begin
        if (sample) shreg[g] <= {shreg[g][BYTE_W-2:0], ser_in[g]};
        if (last)   held[g]  <= {shreg[g][BYTE_W-2:0], ser_in[g]};
      end
    end
  end
endmodule

// File: rtl/tsi_tx.sv
// Parallel-to-serial stage: loads at the slot boundary, shifts at bit ends.
module tsi_tx #(
  parameter int LINKS  = 8,
  parameter int BYTE_W = 8,
  parameter int PH_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PH_W-1:0]               phase,
  input  logic [LINKS-1:0][BYTE_W-1:0]  next_byte,
  output logic [LINKS-1:0]              ser_out
);
  logic [LINKS-1:0][BYTE_W-1:0] shreg;

  for (genvar g = 0; g < LINKS; g++) begin : g_link
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         shreg[g] <= '1;
      else if (&phase)    shreg[g] <= next_byte[g];
      else if (phase[0])  shreg[g] <= {shreg[g][BYTE_W-2:0], 1'b1};
    end
    assign ser_out[g] = shreg[g][BYTE_W-1];
  end
endmodule

// File: rtl/tsi_switch.sv
// Time-slot interchange core. SLOTS and BYTE_W must be powers of two,
// and the speech address ({link, slot}) must fit in one byte field.
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int LINKS  = DEF_LINKS,
  parameter int SLOTS  = DEF_SLOTS,
  parameter int BYTE_W = DEF_BYTE_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             fsync,
  input  logic [LINKS-1:0]                 ser_in,
  output logic [LINKS-1:0]                 ser_out,
  input  logic                             host_valid,
  output logic                             host_ready,
  input  logic                             host_write,
  input  logic [$clog2(LINKS*SLOTS)-1:0]   host_addr,
  input  logic [BYTE_W:0]                  host_wdata,
  output logic                             host_rvalid,
  output logic [BYTE_W:0]                  host_rdata
);
  localparam int LINK_W    = $clog2(LINKS);
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int SLOT_CYC  = 2 * BYTE_W;
  localparam int PH_W      = $clog2(SLOT_CYC);
  localparam int CNT_W     = SLOT_W + PH_W;
  localparam int CH_W      = LINK_W + SLOT_W;
  localparam int ENT_W     = BYTE_W + 1;
  localparam int DEPTH     = LINKS * SLOTS;
  localparam int FRAME_CYC = SLOTS * SLOT_CYC;
  localparam logic [CNT_W-1:0] IN_RST   = CNT_W'(FRAME_CYC - SLOT_CYC);
  localparam logic [CNT_W-1:0] IN_SYNC  = CNT_W'(FRAME_CYC - SLOT_CYC + 1);
  localparam logic [CNT_W-1:0] OUT_RST  = CNT_W'(SLOT_CYC);
  localparam logic [CNT_W-1:0] OUT_SYNC = CNT_W'(SLOT_CYC + 1);
  localparam logic [ENT_W-1:0] IDLE_ENT = '1;

  // Timebases: input lags real time by one slot, output leads by one slot.
  logic [CNT_W-1:0] in_cnt, out_cnt;

  tsi_timebase #(.CNT_W(CNT_W), .RST_VAL(IN_RST), .SYNC_VAL(IN_SYNC)) u_tb_in (
    .clk(clk), .rst_n(rst_n), .sync(fsync), .cnt(in_cnt));
  tsi_timebase #(.CNT_W(CNT_W), .RST_VAL(OUT_RST), .SYNC_VAL(OUT_SYNC)) u_tb_out (
    .clk(clk), .rst_n(rst_n), .sync(fsync), .cnt(out_cnt));

  logic [PH_W-1:0]   in_ph, out_ph;
  logic [SLOT_W-1:0] in_slot, out_slot;
  assign in_ph    = in_cnt[PH_W-1:0];
  assign in_slot  = in_cnt[CNT_W-1:PH_W];
  assign out_ph   = out_cnt[PH_W-1:0];
  assign out_slot = out_cnt[CNT_W-1:PH_W];

  // Receive side and speech memory writes (one link per early cycle).
  logic [LINKS-1:0][BYTE_W-1:0] held;
  tsi_rx #(.LINKS(LINKS), .BYTE_W(BYTE_W), .PH_W(PH_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .phase(in_ph), .ser_in(ser_in), .held(held));

  logic [BYTE_W-1:0] speech [DEPTH];
  logic              sm_we;
  logic [LINK_W-1:0] wr_link;
  assign sm_we   = in_ph < PH_W'(LINKS);
  assign wr_link = in_ph[LINK_W-1:0];

  always_ff @(posedge clk) begin
    if (sm_we) speech[{wr_link, in_slot}] <= held[wr_link];
  end

  // Control memory: fetch owns the first LINKS cycles, host the rest.
  logic             fetch_win, host_go;
  logic [CH_W-1:0]  cm_addr;
  logic [ENT_W-1:0] ctrl [DEPTH];
  logic [ENT_W-1:0] cm_q;

  assign fetch_win  = out_ph < PH_W'(LINKS);
  assign host_ready = !fetch_win;
  assign host_go    = host_valid && host_ready;
  assign cm_addr    = fetch_win ? {out_ph[LINK_W-1:0], out_slot} : host_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctrl[i] <= IDLE_ENT;
    end else if (host_go && host_write) begin
      ctrl[host_addr] <= host_wdata;
    end
  end

  always_ff @(posedge clk) cm_q <= ctrl[cm_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rvalid <= 1'b0;
    else        host_rvalid <= host_go && !host_write;
  end
  assign host_rdata = host_rvalid ? cm_q : '0;

  // Fetch pipeline: entry read, then speech read, then source select.
  logic              f1_v, f2_v;
  logic [LINK_W-1:0] f1_link, f2_link;
  src_sel_e          f2_src;
  logic [BYTE_W-1:0] f2_val, sm_q, sel_byte;
  logic [LINKS-1:0][BYTE_W-1:0] next_byte;

  always_ff @(posedge clk) sm_q <= speech[cm_q[CH_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1_v    <= 1'b0;
      f2_v    <= 1'b0;
      f1_link <= '0;
      f2_link <= '0;
      f2_src  <= SRC_CONST;
      f2_val  <= '1;
    end else begin
      f1_v    <= fetch_win;
      f1_link <= out_ph[LINK_W-1:0];
      f2_v    <= f1_v;
      f2_link <= f1_link;
      f2_src  <= src_sel_e'(cm_q[BYTE_W]);
      f2_val  <= cm_q[BYTE_W-1:0];
    end
  end

  assign sel_byte = (f2_src == SRC_CONST) ? f2_val : sm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    next_byte <= '1;
    else if (f2_v) next_byte[f2_link] <= sel_byte;
  end

  tsi_tx #(.LINKS(LINKS), .BYTE_W(BYTE_W), .PH_W(PH_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .phase(out_ph), .next_byte(next_byte), .ser_out(ser_out));
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int LINKS  = 8,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fsync,
  input logic [LINKS-1:0] ser_out,
  input logic             host_valid,
  input logic             host_ready,
  input logic             host_write,
  input logic             host_rvalid,
  input logic [CNT_W-1:0] in_cnt,
  input logic [CNT_W-1:0] out_cnt
);
  localparam int SLOT_CYC = 2 * BYTE_W;
  localparam int PH_W     = $clog2(SLOT_CYC);

  // R5: an accepted read answers in the very next cycle
  p_read_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && !host_write) |=> host_rvalid);

  // R5: no response strobe without an accepted read
  p_no_stray_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_valid && host_ready && !host_write) |=> !host_rvalid);

  // R6: host slots fall in the second half of the input-side slot as well
  p_host_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (in_cnt[PH_W-1:0] >= PH_W'(LINKS)));

  // R8: no change between the two cycles of one bit
  p_bit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cnt[0] |=> $stable(ser_out));

  // R9: the two timebases stay two slots apart
  p_tb_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt - in_cnt) == CNT_W'(2 * SLOT_CYC));

  // R2: frame pulse puts the output timebase one slot ahead of cycle 1
  p_sync_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> out_cnt == CNT_W'(SLOT_CYC + 1));
endmodule

bind tsi_switch tsi_switch_chk #(.LINKS(LINKS), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .ser_out(ser_out),
  .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
  .host_rvalid(host_rvalid), .in_cnt(in_cnt), .out_cnt(out_cnt));

// File: tb/tb_tsi_switch.sv
`timescale 1ns/1ps
module tb_tsi_switch;
  localparam int FRAME = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync;
  logic [7:0] ser_in;
  logic [7:0] ser_out;
  logic       host_valid = 1'b0;
  logic       host_ready;
  logic       host_write = 1'b0;
  logic [7:0] host_addr = '0;
  logic [8:0] host_wdata = '0;
  logic       host_rvalid;
  logic [8:0] host_rdata;

  always #10 clk = ~clk;

  tsi_switch dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .ser_in(ser_in), .ser_out(ser_out),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata));

  // {address {link,slot}, entry}
  localparam logic [16:0] VEC [8] = '{
    {3'd0, 5'd0,  9'h000},
    {3'd1, 5'd5,  9'h13C},
    {3'd7, 5'd31, 9'h0FF},
    {3'd2, 5'd10, 9'h0E3},
    {3'd5, 5'd0,  9'h100},
    {3'd6, 5'd17, 9'h041},
    {3'd4, 5'd9,  9'h041},
    {3'd3, 5'd30, 9'h01F}
  };

  int  total = 0;
  int  fails = 0;
  int  cyc = FRAME - 1;
  int  frame_no = 0;
  int  glitches = 0;
  bit  run = 1'b0;
  logic [7:0] in_bytes [8][32];
  logic [7:0] cap      [8][32];
  logic [7:0] last_out [8][32];
  logic [7:0] even_val;

  function automatic logic [7:0] pat(input int l, input int s);
    return 8'({l[2:0], s[4:0]}) ^ 8'h5A;
  endfunction

  // Background frame engine: drives serial inputs and fsync, captures outputs.
  always @(negedge clk) begin : bg
    int sl, bi;
    if (run) begin
      cyc = (cyc + 1) % FRAME;
      sl  = cyc / 16;
      bi  = 7 - (cyc % 16) / 2;
      if (cyc % 2 == 0) even_val = ser_out;
      else if (frame_no >= 1 && ser_out !== even_val) glitches++;
      for (int p = 0; p < 8; p++) begin
        if (cyc % 2 == 0) cap[p][sl][bi] = ser_out[p];
        ser_in[p] = in_bytes[p][sl][bi];
      end
      fsync = (cyc == 0);
      if (cyc == FRAME - 1) begin
        last_out = cap;
        frame_no++;
      end
    end else begin
      ser_in = '0;
      fsync  = 1'b0;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_frames(input int n);
    int f0 = frame_no;
    wait (frame_no == f0 + n);
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [8:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [8:0] d, output logic ok);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_addr = a;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    ok = host_rvalid;
    d  = host_rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    logic [8:0] rd;
    logic       ok;
    int         bad;
    for (int l = 0; l < 8; l++)
      for (int s = 0; s < 32; s++) in_bytes[l][s] = pat(l, s);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 ser_out idle", 16'(ser_out), 16'h00FF);
    check("R1 rvalid low", 16'(host_rvalid), 16'h0000);
    host_rd({3'd5, 5'd7}, rd, ok);
    check("R1 R5 reset entry", 16'({ok, rd}), 16'h03FF);

    run = 1'b1;
    wait_frames(2);
    bad = 0;
    for (int l = 0; l < 8; l++)
      for (int s = 0; s < 32; s++) if (last_out[l][s] !== 8'hFF) bad++;
    check("R1 idle frame", 16'(bad), 16'h0000);

    // Vector table: configure, read back, then check switched output.
    for (int i = 0; i < 8; i++) begin
      host_wr(VEC[i][16:9], VEC[i][8:0]);
      host_rd(VEC[i][16:9], rd, ok);
      check("R5 readback", 16'({ok, rd}), 16'({1'b1, VEC[i][8:0]}));
    end
    wait_frames(2);
    for (int i = 0; i < 8; i++) begin
      logic [8:0] e;
      logic [7:0] exp;
      e = VEC[i][8:0];
      exp = e[8] ? e[7:0] : pat(int'(e[7:5]), int'(e[4:0]));
      check(e[8] ? "R4 R2 constant source" : "R3 R2 speech source",
            16'(last_out[VEC[i][16:14]][VEC[i][13:9]]), 16'(exp));
    end

    // R6: host window over one slot
    bad = 0;
    for (int k = 32; k < 48; k++) begin
      wait (cyc == k);
      if (host_ready !== ((k % 16) >= 8)) bad++;
    end
    check("R6 ready window", 16'(bad), 16'h0000);

    // R7 R9: write just after the channel was fetched
    host_wr({3'd1, 5'd12}, 9'h13C);
    wait_frames(1);
    wait (cyc == 16 * 11 + 8);
    host_valid = 1'b1; host_write = 1'b1;
    host_addr = {3'd1, 5'd12}; host_wdata = 9'h1A5;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
    wait_frames(1);
    check("R7 R9 slot in progress kept", 16'(last_out[1][12]), 16'h003C);
    wait_frames(1);
    check("R7 new byte next frame", 16'(last_out[1][12]), 16'h00A5);

    // R10: loop slot 20 of every link onto itself, data changing per frame
    for (int l = 0; l < 8; l++) host_wr(8'({l[2:0], 5'd20}), 9'({1'b0, l[2:0], 5'd20}));
    wait_frames(1);
    for (int l = 0; l < 8; l++) in_bytes[l][20] = 8'h10 + 8'(l);
    wait_frames(1);
    for (int l = 0; l < 8; l++) in_bytes[l][20] = 8'hC0 + 8'(l);
    wait_frames(1);
    for (int l = 0; l < 8; l++)
      check("R10 one-frame loopback", 16'(last_out[l][20]), 16'(8'h10 + 8'(l)));
    wait_frames(1);
    check("R10 next frame", 16'(last_out[3][20]), 16'h00C3);

    check("R8 bit hold", 16'(glitches), 16'h0000);
    finish_run();
  end
endmodule